// File: doc/BRIEF.md
# Serial Receive Status Flag Unit

This block holds the receive-side state of an asynchronous serial port: the last accepted data byte and four status flags (receive buffer full, overrun, parity error and error-signal seen). A deserializer upstream presents each finished character as a one-cycle strobe with the byte and a parity-fault bit. The unit decides whether the character is taken, where it goes and which flag it raises. It also drives a receive-allowed output that tells the deserializer whether it may carry on.

Software reaches the unit through a small register port: address 0 is the status register and address 1 is the data register. A flag can only be dropped with a two-step handshake. Software first performs a read strobe of the status register while the flag is 1, which arms that flag. It then writes 0 to that flag's bit. A pending overrun or parity fault stalls reception until software has cleared it. The error-signal line is active low and is sampled on every clock.

Top module: `rx_status_unit`

## Requirements
- R1: After reset, all four flags and the data register read 0, and rx_allowed equals rx_enable.
- R2: A character strobed while rx_allowed is 1, with no parity fault and the full flag (status bit 0) at 0, is written to the data register and sets the full flag. Both are visible one cycle after the strobe.
- R3: A character strobed while rx_allowed is 1 and the full flag is 1 sets the overrun flag (status bit 1). The data register keeps its earlier byte and the new byte is dropped.
- R4: A character strobed while rx_allowed is 1, with a parity fault and the full flag at 0, is written to the data register and sets the parity flag (status bit 2). The full flag stays 0.
- R5: While the overrun or parity flag is 1, rx_allowed is 0 and strobed characters change neither the data register nor any flag.
- R6: A low level on rx_err_line in a cycle sets the error-signal flag (status bit 3) at the next clock edge. The flag then stays 1 after the line returns high.
- R7: A status write with 0 in a flag's bit clears that flag only if a status read strobe returned that flag as 1 since the flag was last cleared. A write of 0 without that read leaves the flag at 1.
- R8: Writing 1 to any flag bit has no effect on that flag.
- R9: While rx_enable is 0, rx_allowed is 0, strobed characters are ignored, and all flags hold their values.
- R10: When a flag's set condition and its software clear fall in the same cycle, the flag ends at 1.
- R11: cpu_rdata shows the status register for cpu_addr 0 and the data register for cpu_addr 1. Status bits 7 down to 4 always read 0, and a data-register read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done | input | 1 | One-cycle strobe: a character has been received |
| rx_byte | input | DATA_W | Received character |
| rx_parity_err | input | 1 | Parity fault for the strobed character |
| rx_err_line | input | 1 | Sampled error-signal line, active low |
| rx_enable | input | 1 | Receive enable |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 1 | 0 = status register, 1 = data register |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data for the addressed register |
| rx_allowed | output | 1 | Deserializer may continue receiving |

## Verification
A flag register stuck or set wrongly shows on the status read data in the cycle after the bad edge. An overrun or parity flag that is wrongly set also drops rx_allowed in that same cycle. A wrong read-arm bit stays hidden until the next write of 0: it then shows as a flag that fails to clear, or one that clears without the read. For that reason the bench follows arming and clearing across long mixed sequences. It also checks the data register after every cycle, so a byte that is lost or wrongly overwritten is caught on the edge where it happens.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int FLAG_CNT = 4;
    localparam int FLG_FULL = 0;
    localparam int FLG_OVR  = 1;
    localparam int FLG_PAR  = 2;
    localparam int FLG_ESIG = 3;
    localparam logic ADDR_STAT = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    typedef struct packed {
        logic flag;
        logic arm;
    } flag_cell_t;
endpackage

// File: rtl/rxs_flag_cell.sv
module rxs_flag_cell
    import rxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    flag_cell_t st_d, st_q;
    logic       clr;

    always_comb begin
        clr        = wr_i & ~wbit_i & st_q.arm;
        st_d.flag  = set_i | (st_q.flag & ~clr);
        st_d.arm   = (st_q.arm & ~clr) | (rd_i & st_q.flag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/rxs_rx_gate.sv
module rxs_rx_gate (
    input  logic rx_done_i,
    input  logic rx_par_i,
    input  logic rx_en_i,
    input  logic full_i,
    input  logic ovr_i,
    input  logic par_i,
    output logic allowed_o,
    output logic load_o,
    output logic set_full_o,
    output logic set_ovr_o,
    output logic set_par_o
);
    logic accept;

    always_comb begin
        allowed_o  = rx_en_i & ~ovr_i & ~par_i;
        accept     = rx_done_i & allowed_o;
        set_ovr_o  = accept & full_i;
        load_o     = accept & ~full_i;
        set_full_o = load_o & ~rx_par_i;
        set_par_o  = load_o & rx_par_i;
    end
endmodule

// File: rtl/rxs_cpu_port.sv
module rxs_cpu_port
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                addr_i,
    input  logic                rd_i,
    input  logic                wr_i,
    input  logic [FLAG_CNT-1:0] status_i,
    input  logic [DATA_W-1:0]   data_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                stat_rd_o,
    output logic                stat_wr_o
);
    localparam int PAD_W = DATA_W - FLAG_CNT;

    always_comb begin
        stat_rd_o = rd_i & (addr_i == ADDR_STAT);
        stat_wr_o = wr_i & (addr_i == ADDR_STAT);
        if (addr_i == ADDR_DATA) rdata_o = data_i;
        else                     rdata_o = {{PAD_W{1'b0}}, status_i};
    end
endmodule

// File: rtl/rx_status_unit.sv
module rx_status_unit
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_parity_err,
    input  logic              rx_err_line,
    input  logic              rx_enable,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              rx_allowed
);
    logic [FLAG_CNT-1:0] flag_vec;
    logic [FLAG_CNT-1:0] set_vec;
    logic [DATA_W-1:0]   data_d, data_q;
    logic                load, stat_rd, stat_wr;
    logic                unused_wbits;

    assign unused_wbits = ^cpu_wdata[DATA_W-1:FLAG_CNT];

    rxs_rx_gate u_gate (
        .rx_done_i  (rx_done),
        .rx_par_i   (rx_parity_err),
        .rx_en_i    (rx_enable),
        .full_i     (flag_vec[FLG_FULL]),
        .ovr_i      (flag_vec[FLG_OVR]),
        .par_i      (flag_vec[FLG_PAR]),
        .allowed_o  (rx_allowed),
        .load_o     (load),
        .set_full_o (set_vec[FLG_FULL]),
        .set_ovr_o  (set_vec[FLG_OVR]),
        .set_par_o  (set_vec[FLG_PAR])
    );

    assign set_vec[FLG_ESIG] = ~rx_err_line;

    rxs_cpu_port #(.DATA_W(DATA_W)) u_port (
        .addr_i    (cpu_addr),
        .rd_i      (cpu_rd),
        .wr_i      (cpu_wr),
        .status_i  (flag_vec),
        .data_i    (data_q),
        .rdata_o   (cpu_rdata),
        .stat_rd_o (stat_rd),
        .stat_wr_o (stat_wr)
    );

    for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flag
        rxs_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .rd_i   (stat_rd),
            .wr_i   (stat_wr),
            .wbit_i (cpu_wdata[i]),
            .flag_o (flag_vec[i])
        );
    end

    always_comb begin
        data_d = data_q;
        if (load) data_d = rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end
endmodule

// File: rtl/rxs_status_chk.sv
module rxs_status_chk
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rx_done,
    input logic [DATA_W-1:0]   rx_byte,
    input logic                rx_parity_err,
    input logic                rx_err_line,
    input logic                rx_enable,
    input logic                cpu_wr,
    input logic                cpu_addr,
    input logic [DATA_W-1:0]   cpu_wdata,
    input logic                rx_allowed,
    input logic [FLAG_CNT-1:0] flag_vec,
    input logic [DATA_W-1:0]   data_q
);
    AST_CLEAN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && rx_allowed && !rx_parity_err && !flag_vec[FLG_FULL]
        |=> flag_vec[FLG_FULL] && data_q == $past(rx_byte)); // R2

    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && rx_allowed && flag_vec[FLG_FULL]
        |=> flag_vec[FLG_OVR] && $stable(data_q)); // R3

    AST_PARITY_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && rx_allowed && rx_parity_err && !flag_vec[FLG_FULL]
        |=> !flag_vec[FLG_FULL] && flag_vec[FLG_PAR]); // R4

    AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_vec[FLG_OVR] || flag_vec[FLG_PAR]) |-> !rx_allowed); // R5

    AST_ESIG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_err_line |=> flag_vec[FLG_ESIG]); // R6

    AST_OVR_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_vec[FLG_OVR])
        |-> $past(cpu_wr && cpu_addr == ADDR_STAT && !cpu_wdata[FLG_OVR])); // R7

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> $stable(data_q)); // R9

    AST_NO_ALLOW_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |-> !rx_allowed); // R9
endmodule

bind rx_status_unit rxs_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_done       (rx_done),
    .rx_byte       (rx_byte),
    .rx_parity_err (rx_parity_err),
    .rx_err_line   (rx_err_line),
    .rx_enable     (rx_enable),
    .cpu_wr        (cpu_wr),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .rx_allowed    (rx_allowed),
    .flag_vec      (flag_vec),
    .data_q        (data_q)
);

// File: tb/sim_rx_status_unit.sv
`timescale 1ns/1ps
module sim_rx_status_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_done = 1'b0, rx_parity_err = 1'b0, rx_err_line = 1'b1, rx_enable = 1'b1;
    logic       cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_addr = 1'b0;
    logic [7:0] rx_byte = 8'h00, cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       rx_allowed;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [3:0] m_flag = 4'h0;
    logic [3:0] m_arm  = 4'h0;
    logic [7:0] m_data = 8'h00;

    always #2 clk = ~clk;

    rx_status_unit #(.DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
        .rx_parity_err(rx_parity_err), .rx_err_line(rx_err_line), .rx_enable(rx_enable),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .rx_allowed(rx_allowed)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One clock of stimulus; expected state follows from R2..R10.
    task automatic step(input logic done, input logic par, input logic [7:0] b,
                        input logic el, input logic en, input logic rd,
                        input logic wr, input logic addr, input logic [7:0] wd,
                        input string tag);
        logic       acc;
        logic [3:0] setv, clr, rdv;
        @(negedge clk);
        rx_done = done; rx_parity_err = par; rx_byte = b; rx_err_line = el;
        rx_enable = en; cpu_rd = rd; cpu_wr = wr; cpu_addr = addr; cpu_wdata = wd;
        #1;
        chk({7'd0, rx_allowed}, {7'd0, en & ~m_flag[1] & ~m_flag[2]}, {tag, " allowed"});
        if (rd && !addr) chk(cpu_rdata, {4'h0, m_flag}, {tag, " read value"});
        acc     = done & en & ~m_flag[1] & ~m_flag[2];
        setv[0] = acc & ~par & ~m_flag[0];
        setv[1] = acc & m_flag[0];
        setv[2] = acc & par & ~m_flag[0];
        setv[3] = ~el;
        if (acc && !m_flag[0]) m_data = b;
        clr    = (wr && !addr) ? (~wd[3:0] & m_arm) : 4'h0;
        rdv    = (rd && !addr) ? m_flag : 4'h0;
        m_arm  = (m_arm & ~clr) | rdv;
        m_flag = setv | (m_flag & ~clr);
        @(posedge clk);
        #1;
        rx_done = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
        cpu_addr = 1'b1; #0.5;
        chk(cpu_rdata, m_data, {tag, " data reg"});
        cpu_addr = 1'b0; #0.5;
        chk(cpu_rdata, {4'h0, m_flag}, {tag, " status"});
    endtask

    task automatic rx(input logic [7:0] b, input logic par, input string tag);
        step(1'b1, par, b, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, tag);
    endtask
    task automatic rd_stat(input string tag);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, tag);
    endtask
    task automatic wr_stat(input logic [7:0] wd, input string tag);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, wd, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        string       tg;
        repeat (3) @(posedge clk);
        #1;
        cpu_addr = 1'b0; #0.5;
        chk(cpu_rdata, 8'h00, "R1 status in reset");
        chk({7'd0, rx_allowed}, 8'h01, "R1 allowed in reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(cpu_rdata, 8'h00, "R1 status after reset");
        cpu_addr = 1'b1; #0.5;
        chk(cpu_rdata, 8'h00, "R1 data after reset");
        cpu_addr = 1'b0;

        rx(8'hA5, 1'b0, "R2 clean receive");
        chk(cpu_rdata, 8'h01, "R2 full flag bit0");
        rx(8'h3C, 1'b0, "R3 overrun");
        chk(cpu_rdata, 8'h03, "R3 overrun flag bit1");
        cpu_addr = 1'b1; #0.5;
        chk(cpu_rdata, 8'hA5, "R3 earlier byte kept");
        rx(8'h77, 1'b0, "R5 blocked by overrun");
        wr_stat(8'h00, "R7 write 0 without read");
        chk(cpu_rdata, 8'h03, "R7 flags kept without read");
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R11 data read no arm");
        wr_stat(8'h00, "R11 data read left unarmed");
        chk(cpu_rdata, 8'h03, "R11 flags kept after data read");
        rd_stat("R7 arm read");
        wr_stat(8'hFF, "R8 write ones");
        chk(cpu_rdata, 8'h03, "R8 ones no effect");
        wr_stat(8'hF0, "R7 clear after read");
        chk(cpu_rdata, 8'h00, "R7 cleared");

        rx(8'h5A, 1'b1, "R4 parity receive");
        chk(cpu_rdata, 8'h04, "R4 parity set full clear");
        cpu_addr = 1'b1; #0.5;
        chk(cpu_rdata, 8'h5A, "R4 byte loaded");
        rx(8'h11, 1'b0, "R5 blocked by parity");
        step(1'b1, 1'b0, 8'h22, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R9 disabled keeps parity");
        rd_stat("R7 arm parity");
        wr_stat(8'h00, "R7 clear parity");
        step(1'b1, 1'b0, 8'h33, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R9 disabled ignores rx");
        chk(cpu_rdata, 8'h00, "R9 no flag while disabled");

        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R6 line low");
        chk(cpu_rdata, 8'h08, "R6 esig bit3 set");
        rd_stat("R6 line high holds");
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R10 set beats clear");
        chk(cpu_rdata, 8'h08, "R10 esig stays");
        wr_stat(8'h00, "R7 arm used up");
        chk(cpu_rdata, 8'h08, "R7 no second clear");
        rd_stat("R7 rearm");
        wr_stat(8'h00, "R7 clear esig");
        chk(cpu_rdata, 8'h00, "R7 esig cleared");

        lf = 16'hACE1;
        for (int k = 0; k < 4000; k++) begin
            logic [15:0] r;
            r  = lf;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (r[0] & r[1] & (r[2] | r[3])) tg = "R3 R4 R2 sweep receive";
            else if (r[8])                   tg = "R7 R8 sweep write";
            else                             tg = "R6 R9 sweep idle";
            step(r[0] & r[1], r[2] & r[3], r[15:8], |r[6:4], r[5] | r[7] | r[9],
                 r[10], r[8], r[11] & r[12], {r[3:0], r[13:10]}, tg);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule